// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block sits on the target side of an SMBus segment. It raises an open-drain alert request whenever one of two monitored status inputs changes state, and it also raises it once after reset. The host then broadcasts a read to the alert response address. While the alert is pending, the block acknowledges that read and returns its own 8-bit address in the data byte, most significant bit first.

Several alerting devices may answer the same query at once. Each one checks the wired-AND line on every bit, and any device that releases a one but reads back a zero backs off for the rest of the byte. The lowest address therefore reaches the host intact. Only the device that puts its whole address on the bus drops its alert. A device that backs off keeps its request pending, so a later query can pick it up.

Both bus outputs are modelled as pull-down enables: a 1 pulls the line low and a 0 releases it. SCL and SDA are read back through a synchroniser, and the block detects START, STOP and the SCL edges in the system clock domain.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset the alert pull-down is active (power-on alert) and SDA is released.
- R2: While the alert is pending, an address byte equal to the 7-bit alert response address 0x0C followed by a read bit (byte 0x19 on the wire) is acknowledged by pulling SDA low during the ninth clock.
- R3: Any other address byte is not acknowledged, and SDA stays released for the rest of that transfer. This includes the write form 0x18 and unrelated addresses.
- R4: The data byte after the acknowledge carries the value 0x14, most significant bit first.
- R5: If a released (one) bit reads back low on the rising SCL edge, the block stops driving SDA for the rest of the byte, and the host reads the lower competing address.
- R6: The alert is released once all 8 address bits have been sent without losing arbitration.
- R7: After a lost arbitration the alert stays asserted, and the next alert response query is answered with 0x14.
- R8: A change of the AC-present input asserts the alert on the following clock.
- R9: A change of the battery-present input asserts the alert on the following clock.
- R10: A status change that occurs while a response is being sent leaves the alert asserted after that response completes.
- R11: When no alert is pending, a query to the alert response address is not acknowledged.
- R12: The SDA pull-down is only ever engaged while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level as read from the bus |
| sda_i | input | 1 | SDA line level as read from the bus |
| ac_present_i | input | 1 | AC adapter present status |
| batt_present_i | input | 1 | Battery present status |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| alert_pull_o | output | 1 | 1 pulls the alert line low |

## Verification
The bench models a second responder that arbitrates on the same wired-AND SDA line, once with a lower address and once with a higher one. A block that ignored the read-back would corrupt the byte the host receives. A block that released its alert after losing would never be served.

The bench sends the write form of the query address and an unrelated address, to catch a decoder that ignores the direction bit. It also queries while no alert is pending.

A status toggle injected in the middle of the data byte catches a design that clears the alert unconditionally when its address goes out. The bench also counts every engagement of the SDA pull-down while SCL is high, because such an engagement would create a false START.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_SEND,
        ST_WAIT
    } sar_state_e;

    typedef struct packed {
        sar_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  shr;
        logic               ack_on;
        logic               oe;
    } fsm_regs_t;

    typedef struct packed {
        logic alert;
        logic dirty;
    } alert_regs_t;
endpackage

// File: rtl/sar_bus_sync.sv
module sar_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
    logic              scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[TOP-1:0], scl_i};
            sda_pipe_q <= {sda_pipe_q[TOP-1:0], sda_i};
            scl_prev_q <= scl_pipe_q[TOP];
            sda_prev_q <= sda_pipe_q[TOP];
        end
    end

    assign scl_o      = scl_pipe_q[TOP];
    assign sda_o      = sda_pipe_q[TOP];
    assign scl_rise_o = scl_o & ~scl_prev_q;
    assign scl_fall_o = ~scl_o & scl_prev_q;
    assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
    assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;
endmodule

// File: rtl/sar_ara_fsm.sv
module sar_ara_fsm
    import sar_pkg::*;
#(
    parameter logic [6:0]        ARA_ADDR7 = 7'h0C,
    parameter logic [BYTE_W-1:0] RESP_BYTE = 8'h14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_rise_i,
    input  logic scl_fall_i,
    input  logic start_i,
    input  logic stop_i,
    input  logic sda_s_i,
    input  logic alert_active_i,
    output logic sda_oe_o,
    output logic resp_start_o,
    output logic resp_done_o
);
    localparam logic [BYTE_W-1:0] MATCH_BYTE = {ARA_ADDR7, 1'b1};
    localparam logic [CNT_W-1:0]  LAST_BIT   = CNT_W'(BYTE_W - 1);

    fsm_regs_t r_d, r_q;
    logic [BYTE_W-1:0] shr_next;

    always_comb begin
        r_d          = r_q;
        resp_start_o = 1'b0;
        resp_done_o  = 1'b0;
        shr_next     = {r_q.shr[BYTE_W-2:0], sda_s_i};
        if (start_i) begin
            r_d.st     = ST_ADDR;
            r_d.cnt    = '0;
            r_d.oe     = 1'b0;
            r_d.ack_on = 1'b0;
        end else if (stop_i) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_ADDR: if (scl_rise_i) begin
                    r_d.shr = shr_next;
                    if (r_q.cnt == LAST_BIT) begin
                        r_d.cnt    = '0;
                        r_d.ack_on = 1'b0;
                        r_d.st     = (shr_next == MATCH_BYTE && alert_active_i)
                                     ? ST_ACK : ST_WAIT;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_ACK: if (scl_fall_i) begin
                    if (!r_q.ack_on) begin
                        r_d.oe     = 1'b1;
                        r_d.ack_on = 1'b1;
                    end else begin
                        r_d.st       = ST_SEND;
                        r_d.cnt      = '0;
                        r_d.oe       = ~RESP_BYTE[BYTE_W-1];
                        resp_start_o = 1'b1;
                    end
                end
                ST_SEND: begin
                    if (scl_rise_i) begin
                        if (!r_q.oe && !sda_s_i) begin
                            r_d.st = ST_WAIT;
                        end else if (r_q.cnt == LAST_BIT) begin
                            r_d.st      = ST_WAIT;
                            resp_done_o = 1'b1;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end else if (scl_fall_i) begin
                        r_d.oe = ~RESP_BYTE[LAST_BIT - r_q.cnt];
                    end
                end
                ST_WAIT: if (scl_fall_i) r_d.oe = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, shr: '0, ack_on: 1'b0, oe: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o = r_q.oe;
endmodule

// File: rtl/sar_alert_ctrl.sv
module sar_alert_ctrl
    import sar_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic               resp_start_i,
    input  logic               resp_done_i,
    output logic               alert_o
);
    alert_regs_t       r_d, r_q;
    logic [NUM_SRC-1:0] prev_q;
    logic               event_w;

    always_ff @(posedge clk) prev_q <= status_i;

    assign event_w = |(status_i ^ prev_q);

    always_comb begin
        r_d.alert = r_q.alert | event_w;
        r_d.dirty = r_q.dirty | event_w;
        if (resp_start_i) r_d.dirty = event_w;
        if (resp_done_i)  r_d.alert = r_q.dirty | event_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{alert: 1'b1, dirty: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign alert_o = r_q.alert;
endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder #(
    parameter logic [6:0] ARA_ADDR7   = 7'h0C,
    parameter logic [7:0] OWN_ADDR    = 8'h14,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic ac_present_i,
    input  logic batt_present_i,
    output logic sda_pull_o,
    output logic alert_pull_o
);
    localparam int NUM_SRC = 2;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic resp_start, resp_done;

    sar_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    sar_ara_fsm #(.ARA_ADDR7(ARA_ADDR7), .RESP_BYTE(OWN_ADDR)) fsm_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_rise_i     (scl_rise),
        .scl_fall_i     (scl_fall),
        .start_i        (start_det),
        .stop_i         (stop_det),
        .sda_s_i        (sda_s),
        .alert_active_i (alert_pull_o),
        .sda_oe_o       (sda_pull_o),
        .resp_start_o   (resp_start),
        .resp_done_o    (resp_done)
    );

    sar_alert_ctrl #(.NUM_SRC(NUM_SRC)) alert_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .status_i     ({batt_present_i, ac_present_i}),
        .resp_start_i (resp_start),
        .resp_done_i  (resp_done),
        .alert_o      (alert_pull_o)
    );

    logic unused_scl;
    assign unused_scl = scl_s;
endmodule

// File: rtl/sar_checker.sv
module sar_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic ac_present_i,
    input logic batt_present_i,
    input logic sda_pull_o,
    input logic alert_pull_o
);
    a_r12_pull_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_i);

    a_r8_ac_change_alerts: assert property (@(posedge clk) disable iff (!rst_n)
        (ac_present_i != $past(ac_present_i)) |=> alert_pull_o);

    a_r9_batt_change_alerts: assert property (@(posedge clk) disable iff (!rst_n)
        (batt_present_i != $past(batt_present_i)) |=> alert_pull_o);

    a_r11_drive_needs_alert: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> alert_pull_o);
endmodule

bind smb_alert_responder sar_checker chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_i          (scl_i),
    .ac_present_i   (ac_present_i),
    .batt_present_i (batt_present_i),
    .sda_pull_o     (sda_pull_o),
    .alert_pull_o   (alert_pull_o)
);

// File: tb/smb_alert_responder_tb_top.sv
module smb_alert_responder_tb_top;
    localparam int HP = 20;

    typedef struct {
        string      tag;
        logic [7:0] val;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_scl = 1'b1, host_sda = 1'b1, comp_oe = 1'b0;
    logic ac_ok = 1'b1, batt_in = 1'b0;
    logic dut_sda_oe, dut_alert;
    logic sda_line;
    logic oe_prev = 1'b0;
    int   vectors = 0, fails = 0, bad_drive = 0;
    item_t exp_q[$], obs_q[$];

    always #10 clk = ~clk;

    assign sda_line = host_sda & ~dut_sda_oe & ~comp_oe;

    smb_alert_responder dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_i          (host_scl),
        .sda_i          (sda_line),
        .ac_present_i   (ac_ok),
        .batt_present_i (batt_in),
        .sda_pull_o     (dut_sda_oe),
        .alert_pull_o   (dut_alert)
    );

    always @(negedge clk) begin
        if (dut_sda_oe && !oe_prev && host_scl) bad_drive++;
        oe_prev <= dut_sda_oe;
    end

    initial begin
        forever begin
            item_t e, o;
            wait (obs_q.size() > 0 && exp_q.size() > 0);
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            vectors++;
            if (e.val !== o.val) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", e.tag, o.val, e.val);
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] exp, input logic [7:0] act);
        exp_q.push_back('{tag: tag, val: exp});
        obs_q.push_back('{tag: tag, val: act});
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cyc(input logic h, output logic r);
        host_sda = h;
        wait_n(HP);
        host_scl = 1'b1;
        wait_n(HP / 2);
        r = sda_line;
        wait_n(HP / 2);
        host_scl = 1'b0;
    endtask

    task automatic ara_txn(input logic [7:0] abyte, input logic comp_en,
                           input logic [7:0] comp_addr, input logic mid_evt,
                           output logic acked, output logic [7:0] rd);
        logic r;
        logic lost;
        lost = 1'b0;
        host_sda = 1'b1; host_scl = 1'b1; wait_n(HP);
        host_sda = 1'b0; wait_n(HP);
        host_scl = 1'b0;
        for (int i = 7; i >= 0; i--) bit_cyc(abyte[i], r);
        bit_cyc(1'b1, r);
        acked = !r;
        for (int i = 7; i >= 0; i--) begin
            comp_oe = comp_en && !lost && !comp_addr[i];
            if (mid_evt && i == 4) ac_ok = ~ac_ok;
            bit_cyc(1'b1, r);
            rd[i] = r;
            if (comp_en && !lost && comp_addr[i] && !r) lost = 1'b1;
        end
        comp_oe = 1'b0;
        bit_cyc(1'b1, r);
        host_sda = 1'b0; wait_n(HP);
        host_scl = 1'b1; wait_n(HP);
        host_sda = 1'b1; wait_n(HP);
    endtask

    initial begin
        logic ack;
        logic [7:0] rd;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        check("R1 alert after reset", 8'h01, {7'b0, dut_alert});
        check("R1 sda released", 8'h00, {7'b0, dut_sda_oe});

        ara_txn(8'h19, 1'b0, 8'h00, 1'b0, ack, rd);
        check("R2 ack of query", 8'h01, {7'b0, ack});
        check("R4 reply byte", 8'h14, rd);
        check("R6 alert released", 8'h00, {7'b0, dut_alert});

        ara_txn(8'h19, 1'b0, 8'h00, 1'b0, ack, rd);
        check("R11 no ack when idle", 8'h00, {7'b0, ack});
        check("R11 no reply when idle", 8'hFF, rd);

        ac_ok = 1'b0; wait_n(3);
        check("R8 ac change alerts", 8'h01, {7'b0, dut_alert});

        ara_txn(8'h31, 1'b0, 8'h00, 1'b0, ack, rd);
        check("R3 other addr no ack", 8'h00, {7'b0, ack});
        check("R3 other addr no drive", 8'hFF, rd);
        ara_txn(8'h18, 1'b0, 8'h00, 1'b0, ack, rd);
        check("R3 write form no ack", 8'h00, {7'b0, ack});
        check("R3 alert kept", 8'h01, {7'b0, dut_alert});

        ara_txn(8'h19, 1'b1, 8'h10, 1'b0, ack, rd);
        check("R5 lower addr wins", 8'h10, rd);
        check("R7 alert kept on loss", 8'h01, {7'b0, dut_alert});
        ara_txn(8'h19, 1'b0, 8'h00, 1'b0, ack, rd);
        check("R7 later query answered", 8'h14, rd);
        check("R7 alert released later", 8'h00, {7'b0, dut_alert});

        batt_in = 1'b1; wait_n(3);
        check("R9 battery change alerts", 8'h01, {7'b0, dut_alert});
        ara_txn(8'h19, 1'b1, 8'h20, 1'b0, ack, rd);
        check("R5 higher competitor loses", 8'h14, rd);
        check("R6 alert released on win", 8'h00, {7'b0, dut_alert});

        batt_in = 1'b0; wait_n(3);
        check("R9 battery fall alerts", 8'h01, {7'b0, dut_alert});
        ara_txn(8'h19, 1'b0, 8'h00, 1'b1, ack, rd);
        check("R10 reply during event", 8'h14, rd);
        check("R10 alert kept after event", 8'h01, {7'b0, dut_alert});
        ara_txn(8'h19, 1'b0, 8'h00, 1'b0, ack, rd);
        check("R10 cleared on next query", 8'h00, {7'b0, dut_alert});

        check("R12 no pull while scl high", 8'h00, bad_drive[7:0]);

        wait (obs_q.size() == 0);
        wait_n(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule